// File: doc/BRIEF.md
# Five-Stage Pipeline Control Path with Branch Delay Slot and Squash

This block steers a five-stage in-order pipeline: fetch, register read and decode, execute, memory and write-back. It holds the program counter and presents it as the fetch address. The instruction word returned for that address enters decode on the next edge. From then on, the decoded control fields and a valid bit ride with the instruction through one register per stage. Each stage reads its strobes from its own copy of those fields. A new instruction can enter every cycle.

The block covers loads, stores, branch-if-equal, four register-register ALU operations and two immediate ALU operations. ALU results pass through the memory stage unchanged, so the single register-file write port is used only in stage 5 and two instructions can never claim it in the same cycle. A branch resolves in execute, using the equality flag from the datapath, while a separate adder forms the target. The instruction behind the branch is a delay slot and always completes. The instruction fetched while the branch resolves is squashed. An overflow flag from execute is reported only for a valid register-register add or subtract, and that instruction's register write is then dropped.

Top module: `pipe_ctl_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every stage is empty: `rfWe`, `memRead`, `memWrite`, `ovfOut`, `nextPcSel`, `exUseImm` and `exZeroExt` are low, and `pcOut` equals the `RESET_ADDR` parameter.
- R2: When no taken branch is in execute, `pcOut` increases by 4 on every clock edge, fetching one instruction per cycle.
- R3: `ovfOut` is high only in the execute cycle of a valid register-register add or subtract while `ovfFlag` is high. The register write of that instruction is suppressed. An immediate add under a high `ovfFlag` neither reports overflow nor loses its write.
- R4: Instructions are decoded from opcode bits [31:26]. 0 selects register-register, with function bits [5:0] 32 add, 34 sub, 36 and, 37 or. 8 is add-immediate, 13 is or-immediate, 35 is load, 43 is store and 4 is branch-if-equal. Register fields are bits [25:21], [20:16] and [15:11], and the immediate is bits [15:0]. A writing instruction asserts `rfWe` exactly 4 cycles after its fetch cycle. `rfWaddr` is bits [15:11] for register-register and bits [20:16] for add-immediate, or-immediate and load.
- R5: A load asserts `memRead` and a store asserts `memWrite`, each 3 cycles after fetch. Stores and branches never assert `rfWe`.
- R6: A valid branch in execute with `eqFlag` high raises `nextPcSel`. On the next cycle `pcOut` equals the branch address + 4 + (sign-extended immediate × 4).
- R7: The instruction right after a taken branch (the delay slot) completes normally. The one fetched while the branch is in execute is squashed: it never writes, touches memory, reports overflow, branches, or raises execute selects.
- R8: A branch in execute with `eqFlag` low leaves `nextPcSel` low and the fetch sequence unchanged.
- R9: An opcode or function code not listed in R4 behaves as a no-op: it asserts no register write, memory strobe, overflow or branch.
- R10: `exUseImm` is high in execute for valid add-immediate, or-immediate, load and store. `exZeroExt` is high only for valid or-immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrIn | input | 32 | Instruction word read at `pcOut` in the current cycle |
| eqFlag | input | 1 | Operand equality from the execute stage |
| ovfFlag | input | 1 | Arithmetic overflow from the execute stage |
| pcOut | output | PC_W | Fetch address |
| nextPcSel | output | 1 | High when the next PC is the branch target |
| srcRegA | output | 5 | First register read address in decode |
| srcRegB | output | 5 | Second register read address in decode |
| exAluOp | output | 2 | ALU operation in execute (0 add, 1 sub, 2 and, 3 or) |
| exUseImm | output | 1 | Execute takes the immediate as second operand |
| exZeroExt | output | 1 | Immediate is zero-extended rather than sign-extended |
| memRead | output | 1 | Data memory read in stage 4 |
| memWrite | output | 1 | Data memory write in stage 4 |
| ovfOut | output | 1 | Overflow reported for the instruction in execute |
| rfWe | output | 1 | Register-file write enable in stage 5 |
| rfWaddr | output | 5 | Register-file write address in stage 5 |

## Verification
Branch resolution and squash can occur in the same cycle as other pipeline events. While a taken branch redirects fetch, its delay slot sits in decode, the instruction to be squashed is being fetched, and older instructions are writing back or accessing memory. The test program places a load, an immediate add and an overflowing subtract just ahead of a taken branch, so write-backs and a suppressed write overlap the redirect. It also gives the squashed slot an add whose overflow flag is driven high. A reference walk of the fetch stream built from the requirements predicts, for every cycle, the fetch address, the execute selects and the stage-4 and stage-5 strobes. A second taken branch, a not-taken branch and undefined codes are then judged the same way.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LOAD = 6'd35;
  localparam logic [5:0] OP_STOR = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  // Control fields that travel with an instruction into execute.
  typedef struct packed {
    logic              regWrite;
    logic [REG_AW-1:0] dest;
    logic              memRead;
    logic              memWrite;
    logic              isBranch;
    logic              useImm;
    logic              zeroExt;
    logic              ovfCheck;
    alu_op_e           aluOp;
  } stage_ctl_t;

  // Strobes from the control path to the PC datapath.
  typedef struct packed {
    logic takeBranch;
  } pc_strobe_t;

endpackage

// File: rtl/instr_decode.sv
module instr_decode
  import pipe_ctl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output stage_ctl_t         ctl
);

  logic [5:0]        opcode;
  logic [5:0]        funct;
  logic [REG_AW-1:0] rtField;
  logic [REG_AW-1:0] rdField;
  logic              unusedBits;

  assign opcode     = instr[31:26];
  assign funct      = instr[5:0];
  assign rtField    = instr[20:16];
  assign rdField    = instr[15:11];
  assign unusedBits = ^{instr[25:21], instr[10:6]};

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_ADD;
    case (opcode)
      OP_REG: begin
        ctl.dest = rdField;
        case (funct)
          FN_ADD: begin ctl.regWrite = 1'b1; ctl.ovfCheck = 1'b1; ctl.aluOp = ALU_ADD; end
          FN_SUB: begin ctl.regWrite = 1'b1; ctl.ovfCheck = 1'b1; ctl.aluOp = ALU_SUB; end
          FN_AND: begin ctl.regWrite = 1'b1; ctl.aluOp = ALU_AND; end
          FN_OR:  begin ctl.regWrite = 1'b1; ctl.aluOp = ALU_OR;  end
          default: ctl.dest = '0;
        endcase
      end
      OP_ADDI: begin
        ctl.regWrite = 1'b1; ctl.dest = rtField; ctl.useImm = 1'b1;
      end
      OP_ORI: begin
        ctl.regWrite = 1'b1; ctl.dest = rtField; ctl.useImm = 1'b1;
        ctl.zeroExt  = 1'b1; ctl.aluOp = ALU_OR;
      end
      OP_LOAD: begin
        ctl.regWrite = 1'b1; ctl.dest = rtField; ctl.useImm = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_STOR: begin
        ctl.useImm = 1'b1; ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.isBranch = 1'b1; ctl.aluOp = ALU_SUB;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrIn,
  input  logic               eqFlag,
  input  logic               ovfFlag,
  output pc_strobe_t         strobe,
  output logic [REG_AW-1:0]  srcRegA,
  output logic [REG_AW-1:0]  srcRegB,
  output logic [1:0]         exAluOp,
  output logic               exUseImm,
  output logic               exZeroExt,
  output logic               memRead,
  output logic               memWrite,
  output logic               ovfOut,
  output logic               rfWe,
  output logic [REG_AW-1:0]  rfWaddr
);

  // decode stage
  logic [INSTR_W-1:0] idInstr;
  logic               idValid;
  stage_ctl_t         idCtl;
  // execute stage
  stage_ctl_t         exCtl;
  logic               exValid;
  // memory stage
  logic               memValid, memWe, memRd, memWr;
  logic [REG_AW-1:0]  memDest;
  // write-back stage
  logic               wbValid, wbWe;
  logic [REG_AW-1:0]  wbDest;

  logic takeBranch;
  logic ovfHit;

  instr_decode decode_i (
    .instr (idInstr),
    .ctl   (idCtl)
  );

  assign takeBranch = exValid & exCtl.isBranch & eqFlag;
  assign ovfHit     = exValid & exCtl.ovfCheck & ovfFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idInstr  <= '0;
      idValid  <= 1'b0;
      exCtl    <= '0;
      exValid  <= 1'b0;
      memValid <= 1'b0;
      memWe    <= 1'b0;
      memRd    <= 1'b0;
      memWr    <= 1'b0;
      memDest  <= '0;
      wbValid  <= 1'b0;
      wbWe     <= 1'b0;
      wbDest   <= '0;
    end else begin
      // the word being fetched while a branch resolves is squashed
      idInstr  <= instrIn;
      idValid  <= ~takeBranch;
      exCtl    <= idCtl;
      exValid  <= idValid;
      memValid <= exValid;
      memWe    <= exCtl.regWrite & ~ovfHit;
      memRd    <= exCtl.memRead;
      memWr    <= exCtl.memWrite;
      memDest  <= exCtl.dest;
      wbValid  <= memValid;
      wbWe     <= memWe;
      wbDest   <= memDest;
    end
  end

  assign strobe.takeBranch = takeBranch;
  assign srcRegA   = idInstr[25:21];
  assign srcRegB   = idInstr[20:16];
  assign exAluOp   = exCtl.aluOp;
  assign exUseImm  = exValid & exCtl.useImm;
  assign exZeroExt = exValid & exCtl.zeroExt;
  assign ovfOut    = ovfHit;
  assign memRead   = memValid & memRd;
  assign memWrite  = memValid & memWr;
  assign rfWe      = wbValid & wbWe;
  assign rfWaddr   = rfWe ? wbDest : '0;

endmodule

// File: rtl/pc_path.sv
module pc_path
  import pipe_ctl_pkg::*;
#(
  parameter int unsigned      PC_W       = 32,
  parameter logic [PC_W-1:0]  RESET_ADDR = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IMM_W-1:0] immIn,
  input  pc_strobe_t       strobe,
  output logic [PC_W-1:0]  pcOut
);

  localparam int SEXT_W = PC_W - IMM_W - 2;

  logic [PC_W-1:0]  pc, idPcNext, exPcNext, target;
  logic [IMM_W-1:0] idImm, exImm;

  // dedicated target adder, independent of the ALU
  assign target = exPcNext + {{SEXT_W{exImm[IMM_W-1]}}, exImm, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= RESET_ADDR;
      idPcNext <= '0;
      exPcNext <= '0;
      idImm    <= '0;
      exImm    <= '0;
    end else begin
      pc       <= strobe.takeBranch ? target : pc + PC_W'(4);
      idPcNext <= pc + PC_W'(4);
      exPcNext <= idPcNext;
      idImm    <= immIn;
      exImm    <= idImm;
    end
  end

  assign pcOut = pc;

endmodule

// File: rtl/pipe_ctl_top.sv
module pipe_ctl_top
  import pipe_ctl_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instrIn,
  input  logic              eqFlag,
  input  logic              ovfFlag,
  output logic [PC_W-1:0]   pcOut,
  output logic              nextPcSel,
  output logic [4:0]        srcRegA,
  output logic [4:0]        srcRegB,
  output logic [1:0]        exAluOp,
  output logic              exUseImm,
  output logic              exZeroExt,
  output logic              memRead,
  output logic              memWrite,
  output logic              ovfOut,
  output logic              rfWe,
  output logic [4:0]        rfWaddr
);

  pc_strobe_t strobe;

  pipe_ctl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instrIn   (instrIn),
    .eqFlag    (eqFlag),
    .ovfFlag   (ovfFlag),
    .strobe    (strobe),
    .srcRegA   (srcRegA),
    .srcRegB   (srcRegB),
    .exAluOp   (exAluOp),
    .exUseImm  (exUseImm),
    .exZeroExt (exZeroExt),
    .memRead   (memRead),
    .memWrite  (memWrite),
    .ovfOut    (ovfOut),
    .rfWe      (rfWe),
    .rfWaddr   (rfWaddr)
  );

  pc_path #(.PC_W(PC_W), .RESET_ADDR(RESET_ADDR)) pc_i (
    .clk    (clk),
    .rstN   (rstN),
    .immIn  (instrIn[15:0]),
    .strobe (strobe),
    .pcOut  (pcOut)
  );

  assign nextPcSel = strobe.takeBranch;

endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk #(
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_ADDR = '0
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] pcOut,
  input logic            nextPcSel,
  input logic            memRead,
  input logic            memWrite,
  input logic            ovfOut,
  input logic            rfWe
);

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pcOut == RESET_ADDR) && !rfWe && !memRead && !memWrite);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rstN)
    !nextPcSel |=> pcOut == $past(pcOut) + PC_W'(4));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> ##2 !rfWe);

  assert_store_nowrite_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> !rfWe);

  assert_squash_nobranch_R7: assert property (@(posedge clk) disable iff (!rstN)
    nextPcSel |-> ##2 !nextPcSel && !ovfOut);

  assert_squash_nomem_R7: assert property (@(posedge clk) disable iff (!rstN)
    nextPcSel |-> ##3 !memRead && !memWrite);

  assert_squash_nowrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    nextPcSel |-> ##4 !rfWe);

endmodule

bind pipe_ctl_top pipe_ctl_chk #(.PC_W(PC_W), .RESET_ADDR(RESET_ADDR)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .pcOut     (pcOut),
  .nextPcSel (nextPcSel),
  .memRead   (memRead),
  .memWrite  (memWrite),
  .ovfOut    (ovfOut),
  .rfWe      (rfWe)
);

// File: tb/pipe_ctl_top_tb_top.sv
`timescale 1ns/1ps
module pipe_ctl_top_tb_top;

  localparam int          PC_W   = 32;
  localparam logic [31:0] RST_PC = 32'h100;
  localparam int          NCYC   = 40;
  localparam int          PROG_N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrIn;
  logic eqFlag, ovfFlag;
  logic [PC_W-1:0] pcOut;
  logic nextPcSel, exUseImm, exZeroExt, memRead, memWrite, ovfOut, rfWe;
  logic [4:0] srcRegA, srcRegB, rfWaddr;
  logic [1:0] exAluOp;

  always #10 clk = ~clk;

  pipe_ctl_top #(.PC_W(PC_W), .RESET_ADDR(RST_PC)) dut_i (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .eqFlag(eqFlag), .ovfFlag(ovfFlag),
    .pcOut(pcOut), .nextPcSel(nextPcSel), .srcRegA(srcRegA), .srcRegB(srcRegB),
    .exAluOp(exAluOp), .exUseImm(exUseImm), .exZeroExt(exZeroExt),
    .memRead(memRead), .memWrite(memWrite), .ovfOut(ovfOut),
    .rfWe(rfWe), .rfWaddr(rfWaddr)
  );

  logic [31:0] prog [PROG_N];
  logic        eqTab [PROG_N];
  logic        ovTab [PROG_N];
  logic [31:0] hist1 = '0, hist2 = '0;
  int checks = 0, errors = 0;

  typedef struct {
    bit wr; logic [4:0] dst; bit ld, st, br, chk, imm, zx, unk;
  } info_t;
  typedef struct { int cyc; logic [4:0] a; } ev_t;

  ev_t wbQ[$];
  int  mrQ[$], mwQ[$], ovQ[$];
  logic [31:0] pcs [NCYC+1];
  bit val [NCYC+1];
  bit expSel [NCYC], expImm [NCYC], expZx [NCYC], expNt [NCYC];

  function automatic int idxOf(logic [31:0] pc);
    logic [31:0] off;
    if (pc < RST_PC || pc[1:0] != 2'b00) return -1;
    off = (pc - RST_PC) >> 2;
    if (off >= PROG_N) return -1;
    return int'(off);
  endfunction

  function automatic logic [31:0] wordAt(logic [31:0] pc);
    int i;
    i = idxOf(pc);
    return (i < 0) ? 32'h0 : prog[i];
  endfunction

  function automatic logic eqAt(logic [31:0] pc);
    int i;
    i = idxOf(pc);
    return (i < 0) ? 1'b0 : eqTab[i];
  endfunction

  function automatic logic ovAt(logic [31:0] pc);
    int i;
    i = idxOf(pc);
    return (i < 0) ? 1'b0 : ovTab[i];
  endfunction

  function automatic logic [31:0] rEnc(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] iEnc(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // decoding per the encodings stated in R4
  function automatic info_t classify(logic [31:0] w);
    info_t r;
    r = '{default: 0};
    case (w[31:26])
      6'd0: begin
        if (w[5:0] == 6'd32 || w[5:0] == 6'd34) begin r.wr = 1; r.chk = 1; r.dst = w[15:11]; end
        else if (w[5:0] == 6'd36 || w[5:0] == 6'd37) begin r.wr = 1; r.dst = w[15:11]; end
        else r.unk = (w != 32'h0);
      end
      6'd8:  begin r.wr = 1; r.dst = w[20:16]; r.imm = 1; end
      6'd13: begin r.wr = 1; r.dst = w[20:16]; r.imm = 1; r.zx = 1; end
      6'd35: begin r.wr = 1; r.dst = w[20:16]; r.imm = 1; r.ld = 1; end
      6'd43: begin r.st = 1; r.imm = 1; end
      6'd4:  r.br = 1;
      default: r.unk = 1;
    endcase
    return r;
  endfunction

  always_comb instrIn = wordAt(pcOut);
  always_comb eqFlag  = eqAt(hist2);
  always_comb ovfFlag = ovAt(hist2);

  always @(posedge clk) begin
    hist1 <= pcOut;
    hist2 <= hist1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadProgram();
    for (int i = 0; i < PROG_N; i++) begin prog[i] = 32'h0; eqTab[i] = 0; ovTab[i] = 0; end
    prog[0]  = iEnc(35, 2, 1, 35);                 // load r1
    prog[1]  = iEnc(8, 2, 2, 3);                   // add-imm r2
    prog[2]  = rEnc(4, 5, 3, 34);  ovTab[2] = 1;   // sub r3, overflows
    prog[3]  = iEnc(4, 6, 7, 8);   eqTab[3] = 1;   // taken -> index 12
    prog[4]  = iEnc(13, 9, 8, 17);                 // delay slot: or-imm r8
    prog[5]  = rEnc(11, 12, 10, 32); ovTab[5] = 1; // squashed add
    prog[12] = rEnc(14, 15, 13, 36);               // and r13
    prog[13] = iEnc(43, 2, 1, 0);                  // store
    prog[14] = iEnc(4, 1, 1, 5);                   // not taken
    prog[15] = rEnc(3, 3, 16, 32);                 // add r16
    prog[16] = iEnc(4, 1, 1, 3);   eqTab[16] = 1;  // taken -> index 20
    prog[17] = iEnc(35, 0, 17, 4);                 // delay slot: load r17
    prog[18] = iEnc(13, 0, 18, 5);                 // squashed or-imm
    prog[20] = iEnc(8, 0, 20, 1);  ovTab[20] = 1;  // add-imm, no overflow
    prog[21] = iEnc(63, 0, 21, 1);                 // undefined opcode
    prog[22] = rEnc(1, 2, 22, 39);                 // undefined function
  endtask

  // Driver: walk the fetch stream and push expected strobes.
  task automatic buildModel();
    pcs[0] = RST_PC;
    for (int t = 0; t <= NCYC; t++) val[t] = 1;
    for (int t = 0; t < NCYC; t++) begin
      logic [31:0] nxt, w;
      info_t b;
      nxt = pcs[t] + 4;
      expSel[t] = 0; expImm[t] = 0; expZx[t] = 0; expNt[t] = 0;
      if (t >= 2 && val[t-2]) begin
        w = wordAt(pcs[t-2]);
        b = classify(w);
        expImm[t] = b.imm;
        expZx[t]  = b.zx;
        if (b.br && eqAt(pcs[t-2])) begin
          expSel[t] = 1;
          nxt = pcs[t-2] + 4 + {{14{w[15]}}, w[15:0], 2'b00};
          val[t] = 0;
        end else if (b.br) expNt[t] = 1;
      end
      pcs[t+1] = nxt;
    end
    for (int t = 0; t < NCYC; t++) begin
      info_t r;
      if (val[t]) begin
        r = classify(wordAt(pcs[t]));
        if (r.chk && ovAt(pcs[t])) ovQ.push_back(t + 2);
        else if (r.wr) wbQ.push_back('{t + 4, r.dst});
        if (r.ld) mrQ.push_back(t + 3);
        if (r.st) mwQ.push_back(t + 3);
      end
    end
  endtask

  // Monitor: compare outputs in cycle t against the expected items.
  task automatic monitorStep(int t);
    bit e;
    info_t old;
    chk((t > 0 && expSel[t-1]) ? "R6 target pc" : "R2 pc", pcOut, pcs[t]);
    chk(expNt[t] ? "R8 not taken" : "R6 next-pc select", 32'(nextPcSel), 32'(expSel[t]));
    chk("R10 use-imm", 32'(exUseImm), 32'(expImm[t]));
    chk("R10 zero-ext", 32'(exZeroExt), 32'(expZx[t]));
    e = (wbQ.size() > 0 && wbQ[0].cyc == t);
    chk("R4 write enable", 32'(rfWe), 32'(e));
    if (e) begin chk("R4 write address", 32'(rfWaddr), 32'(wbQ[0].a)); void'(wbQ.pop_front()); end
    e = (mrQ.size() > 0 && mrQ[0] == t);
    chk("R5 mem read", 32'(memRead), 32'(e));
    if (e) void'(mrQ.pop_front());
    e = (mwQ.size() > 0 && mwQ[0] == t);
    chk("R5 mem write", 32'(memWrite), 32'(e));
    if (e) void'(mwQ.pop_front());
    e = (ovQ.size() > 0 && ovQ[0] == t);
    chk("R3 overflow", 32'(ovfOut), 32'(e));
    if (e) void'(ovQ.pop_front());
    if (t >= 2 && !val[t-2]) begin
      chk("R7 squashed no overflow", 32'(ovfOut), 32'd0);
      chk("R7 squashed no select", 32'({nextPcSel, exUseImm}), 32'd0);
    end
    if (t >= 4 && !val[t-4]) chk("R7 squashed no write", 32'(rfWe), 32'd0);
    if (t >= 4 && val[t-4]) begin
      old = classify(wordAt(pcs[t-4]));
      if (old.unk) chk("R9 undefined code inert", 32'(rfWe), 32'd0);
      if (old.st || old.br) chk("R5 store/branch no write", 32'(rfWe), 32'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    loadProgram();
    buildModel();
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pcOut, RST_PC);
    chk("R1 reset strobes", 32'({rfWe, memRead, memWrite, ovfOut, nextPcSel, exUseImm, exZeroExt}), 32'd0);
    rstN = 1'b1;
    for (int t = 0; t < NCYC; t++) begin
      monitorStep(t);
      @(negedge clk);
    end
    chk("R4 all writes seen", 32'(wbQ.size()), 32'd0);
    chk("R5 all memory strobes seen", 32'(mrQ.size() + mwQ.size()), 32'd0);
    chk("R3 all overflows seen", 32'(ovQ.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule